// File: doc/BRIEF.md
# Segment Lookaside Buffer with Bulk Invalidate

This block keeps a small, fully associative table of segment translations. Each slot holds a valid flag, an effective segment tag, a virtual segment tag and a one-bit class marker. Software fills slots through a write port. It can read any slot back combinationally, including its valid flag and the other fields.

A bulk-invalidate command carries the raw instruction word. The block takes a 3-bit hint from bits 23..21 and then visits the slots one per clock, dropping valid flags by the rule that the hint and the mode input select. Depending on the hint, a command can spare slot 0 or include it, keep class-0 slots alive, or leave the table alone and only request a flush.

Every command raises a translation-cache flush request. The request is held until it is acknowledged. An undefined hint value raises a sticky error flag.

Top module: `slb_inval_engine`

## Requirements
- R1: The hint is `cmd_insn[23:21]`. No other instruction bit changes the result.
- R2: With `ext_mode`=0 (any hint), or with `ext_mode`=1 and hint 0, 1, 2 or 6, the sweep visits slots 1..N-1 and clears every valid flag there. Slot 0 keeps its valid flag.
- R3: With `ext_mode`=1 and hint 4, the sweep starts at slot 0 and clears every valid flag, slot 0 included.
- R4: With `ext_mode`=1 and hint 3, the sweep starts at slot 0. A valid slot whose class bit is 0 keeps its valid flag, and a valid slot with class bit 1 is cleared.
- R5: With `ext_mode`=1 and hint 7, no valid flag changes. The command finishes in one cycle: `busy` and `done` are both high in the cycle after acceptance.
- R6: With `ext_mode`=1 and hint 5, the block acts as for hint 0 and sets `bad_hint`. Only reset clears `bad_hint`. In legacy mode, hint 5 leaves `bad_hint` unchanged.
- R7: Invalidation clears only the valid flag. The segment tags and the class bit of every slot keep their values.
- R8: An accepted command sets `flush_req` in the next cycle. `flush_req` stays high until `flush_ack` is sampled high, and a new command takes priority over an acknowledge in the same cycle.
- R9: A sweep starting at slot s keeps `busy` high for N-s+1 cycles after acceptance. `done` is high for exactly one of those cycles, the last one.
- R10: A write is ignored while `busy` is high, and also when `cmd_valid` is high in the same cycle. A command is accepted only when `busy` is low.
- R11: After reset all valid flags are 0, and `busy`, `done`, `flush_req` and `bad_hint` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_valid | input | 1 | Valid flag to write |
| wr_esid | input | ESID_W | Effective segment tag to write |
| wr_vsid | input | VSID_W | Virtual segment tag to write |
| wr_class | input | 1 | Class bit to write |
| rd_idx | input | IDX_W | Slot to read back |
| rd_valid | output | 1 | Valid flag of slot `rd_idx` |
| rd_esid | output | ESID_W | Effective tag of slot `rd_idx` |
| rd_vsid | output | VSID_W | Virtual tag of slot `rd_idx` |
| rd_class | output | 1 | Class bit of slot `rd_idx` |
| cmd_valid | input | 1 | Bulk-invalidate command strobe |
| cmd_insn | input | INSN_W | Raw instruction word |
| ext_mode | input | 1 | 1 selects the extended hint meanings |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| flush_req | output | 1 | Translation-cache flush request |
| flush_ack | input | 1 | Clears `flush_req` |
| bad_hint | output | 1 | Sticky flag for an undefined hint |

## Verification
The table is loaded with alternating class bits and distinct tags. Every hint value is then issued in both modes. The resulting valid mask separates the slot-0-sparing rule, the full sweep and the class-preserving sweep. It also separates the no-op hint from all of them.

Each command is issued with noise in the instruction bits next to the hint field, so a wrong field position shows up. Latency counting separates a start at slot 0 from a start at slot 1, and separates the single-cycle no-op from a full sweep.

Writes issued during a sweep, and in the same cycle as a command, show whether the stall is honoured. Readback of tags and class after each command shows whether anything other than the valid flag was disturbed.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int HINT_LSB = 21;
  localparam int HINT_W   = 3;

  typedef struct packed {
    logic sweep;      // walk the table
    logic from_zero;  // include slot 0
    logic keep_c0;    // spare class-0 slots
    logic illegal;    // undefined hint
  } slb_hint_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_FIN   = 2'd2
  } slb_state_t;
endpackage

// File: rtl/slb_hint_decode.sv
module slb_hint_decode
  import slb_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              ext_mode,
  output slb_hint_t         dec
);
  logic [HINT_W-1:0] hint;
  assign hint = insn[HINT_LSB +: HINT_W];

  always_comb begin
    dec.sweep     = 1'b1;
    dec.from_zero = 1'b0;
    dec.keep_c0   = 1'b0;
    dec.illegal   = 1'b0;
    if (ext_mode) begin
      case (hint)
        3'd3: begin
          dec.from_zero = 1'b1;
          dec.keep_c0   = 1'b1;
        end
        3'd4: dec.from_zero = 1'b1;
        3'd5: dec.illegal   = 1'b1;
        3'd7: dec.sweep     = 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/slb_sweep_ctrl.sv
module slb_sweep_ctrl
  import slb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  slb_hint_t        dec,
  output logic             busy,
  output logic             done,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             keep_c0
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  slb_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             keep_q, keep_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    keep_d  = keep_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (dec.sweep) begin
            state_d = ST_SWEEP;
            idx_d   = dec.from_zero ? '0 : IDX_W'(1);
            keep_d  = dec.keep_c0;
          end else begin
            state_d = ST_FIN;
          end
        end
      end
      ST_SWEEP: begin
        if (idx_q == LAST) state_d = ST_FIN;
        else               idx_d   = idx_q + IDX_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      keep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      keep_q  <= keep_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FIN);
  assign clr_en  = (state_q == ST_SWEEP);
  assign clr_idx = idx_q;
  assign keep_c0 = keep_q;
endmodule

// File: rtl/slb_entry_array.sv
module slb_entry_array #(
  parameter int N_ENTRIES = 32,
  parameter int ESID_W    = 16,
  parameter int VSID_W    = 24,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_valid,
  input  logic [ESID_W-1:0]    wr_esid,
  input  logic [VSID_W-1:0]    wr_vsid,
  input  logic                 wr_class,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 keep_c0,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_valid,
  output logic [ESID_W-1:0]    rd_esid,
  output logic [VSID_W-1:0]    rd_vsid,
  output logic                 rd_class,
  output logic [N_ENTRIES-1:0] vld_o
);
  logic [ESID_W-1:0] esid_a [N_ENTRIES];
  logic [VSID_W-1:0] vsid_a [N_ENTRIES];
  logic [N_ENTRIES-1:0] cls_a;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic              v_q, v_d;
    logic [ESID_W-1:0] e_q;
    logic [VSID_W-1:0] s_q;
    logic              c_q;
    logic              wr_hit, clr_hit;

    assign wr_hit  = wr_en && (wr_idx == GI);
    assign clr_hit = clr_en && (clr_idx == GI) && v_q && !(keep_c0 && !c_q);

    always_comb begin
      v_d = v_q;
      if (clr_hit) v_d = 1'b0;
      if (wr_hit)  v_d = wr_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (wr_hit) begin
        e_q <= wr_esid;
        s_q <= wr_vsid;
        c_q <= wr_class;
      end
    end

    assign vld_o[g]  = v_q;
    assign esid_a[g] = e_q;
    assign vsid_a[g] = s_q;
    assign cls_a[g]  = c_q;
  end

  assign rd_valid = vld_o[rd_idx];
  assign rd_esid  = esid_a[rd_idx];
  assign rd_vsid  = vsid_a[rd_idx];
  assign rd_class = cls_a[rd_idx];
endmodule

// File: rtl/slb_inval_engine.sv
module slb_inval_engine
  import slb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int ESID_W    = 16,
  parameter int VSID_W    = 24,
  parameter int INSN_W    = 32,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ESID_W-1:0] wr_esid,
  input  logic [VSID_W-1:0] wr_vsid,
  input  logic              wr_class,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ESID_W-1:0] rd_esid,
  output logic [VSID_W-1:0] rd_vsid,
  output logic              rd_class,
  input  logic              cmd_valid,
  input  logic [INSN_W-1:0] cmd_insn,
  input  logic              ext_mode,
  output logic              busy,
  output logic              done,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic              bad_hint
);
  slb_hint_t            dec;
  logic                 accept, wr_ok;
  logic                 clr_en, keep_c0;
  logic [IDX_W-1:0]     clr_idx;
  logic [N_ENTRIES-1:0] vld_w;
  logic                 flush_q, flush_d, bad_q, bad_d;

  slb_hint_decode #(.INSN_W(INSN_W)) u_dec (
    .insn(cmd_insn), .ext_mode(ext_mode), .dec(dec)
  );

  assign accept = cmd_valid && !busy;
  assign wr_ok  = wr_en && !busy && !cmd_valid;

  slb_sweep_ctrl #(.N_ENTRIES(N_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(accept), .dec(dec),
    .busy(busy), .done(done), .clr_en(clr_en), .clr_idx(clr_idx),
    .keep_c0(keep_c0)
  );

  slb_entry_array #(.N_ENTRIES(N_ENTRIES), .ESID_W(ESID_W), .VSID_W(VSID_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_esid(wr_esid), .wr_vsid(wr_vsid), .wr_class(wr_class),
    .clr_en(clr_en), .clr_idx(clr_idx), .keep_c0(keep_c0),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_esid(rd_esid),
    .rd_vsid(rd_vsid), .rd_class(rd_class), .vld_o(vld_w)
  );

  always_comb begin
    flush_d = flush_q;
    if (flush_ack) flush_d = 1'b0;
    if (accept)    flush_d = 1'b1;
    bad_d = bad_q | (accept & dec.illegal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      flush_q <= flush_d;
      bad_q   <= bad_d;
    end
  end

  assign flush_req = flush_q;
  assign bad_hint  = bad_q;
endmodule

// File: rtl/slb_inval_checker.sv
module slb_inval_checker #(
  parameter int N_ENTRIES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 ext_mode,
  input logic [2:0]           hint,
  input logic                 busy,
  input logic                 done,
  input logic                 flush_req,
  input logic                 flush_ack,
  input logic                 bad_hint,
  input logic [N_ENTRIES-1:0] vld
);
  logic spare0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spare0_q <= 1'b0;
    else if (cmd_valid && !busy)
      spare0_q <= !ext_mode || !((hint == 3'd3) || (hint == 3'd4));
  end

  p_slot0_spared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && spare0_q) |=> $stable(vld[0]));

  p_noop_hint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && ext_mode && hint == 3'd7) |=> (done && $stable(vld)));

  p_bad_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_hint |=> bad_hint);

  p_flush_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> flush_req);

  p_flush_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req);

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_set_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((vld & ~$past(vld)) == '0));
endmodule

bind slb_inval_engine slb_inval_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .ext_mode(ext_mode),
  .hint(cmd_insn[23:21]), .busy(busy), .done(done), .flush_req(flush_req),
  .flush_ack(flush_ack), .bad_hint(bad_hint), .vld(vld_w)
);

// File: tb/sim_slb_inval_engine.sv
`timescale 1ns/100ps
module sim_slb_inval_engine;
  localparam int N  = 32;
  localparam int IW = $clog2(N);
  localparam int EW = 16;
  localparam int VW = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_valid, wr_class;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [EW-1:0] wr_esid, rd_esid;
  logic [VW-1:0] wr_vsid, rd_vsid;
  logic rd_valid, rd_class;
  logic cmd_valid, ext_mode, flush_ack;
  logic [31:0] cmd_insn;
  logic busy, done, flush_req, bad_hint;

  always #2.5 clk = ~clk;

  slb_inval_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_esid(wr_esid), .wr_vsid(wr_vsid),
    .wr_class(wr_class), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_esid(rd_esid), .rd_vsid(rd_vsid), .rd_class(rd_class),
    .cmd_valid(cmd_valid), .cmd_insn(cmd_insn), .ext_mode(ext_mode),
    .busy(busy), .done(done), .flush_req(flush_req),
    .flush_ack(flush_ack), .bad_hint(bad_hint)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;

  logic [N-1:0]  m_vld;
  logic [EW-1:0] m_esid [N];
  logic [VW-1:0] m_vsid [N];
  logic [N-1:0]  m_cls;
  logic          m_bad;

  typedef struct {
    logic [N-1:0] vld;
    int           lat;
    logic         bad;
    string        tag;
  } item_t;
  item_t sb_q[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_all(output logic [N-1:0] v, output logic fields_ok);
    fields_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #0.1;
      v[i] = rd_valid;
      if (rd_esid !== m_esid[i] || rd_vsid !== m_vsid[i] || rd_class !== m_cls[i])
        fields_ok = 1'b0;
    end
  endtask

  task automatic wr_slot(input int i, input logic v, input logic [EW-1:0] e,
                         input logic [VW-1:0] s, input logic c);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(i); wr_valid = v;
    wr_esid = e; wr_vsid = s; wr_class = c;
    @(negedge clk);
    wr_en = 1'b0;
    m_vld[i] = v; m_esid[i] = e; m_vsid[i] = s; m_cls[i] = c;
  endtask

  task automatic fill_all();
    for (int i = 0; i < N; i++)
      wr_slot(i, 1'b1, EW'(i * 37 + 5), VW'(i * 1013 + 9), i[0]);
  endtask

  // Driver: computes the expected outcome from the requirements, queues it, drives.
  task automatic run_cmd(input logic [2:0] hint, input logic ext, input logic [31:0] noise,
                         input bit wr_same, input bit wr_during, input string tag);
    item_t it;
    int    start;
    bit    sweep, keep0;
    int    target;
    start = 1; sweep = 1; keep0 = 0;
    if (ext) begin
      if (hint == 3'd3) begin start = 0; keep0 = 1; end
      if (hint == 3'd4) start = 0;
      if (hint == 3'd7) sweep = 0;
      if (hint == 3'd5) m_bad = 1'b1;
    end
    if (sweep)
      for (int i = start; i < N; i++)
        if (!(keep0 && !m_cls[i])) m_vld[i] = 1'b0;
    it.vld = m_vld;
    it.lat = sweep ? (N - start + 1) : 1;
    it.bad = m_bad;
    it.tag = tag;
    sb_q.push_back(it);
    target = n_done + 1;
    @(negedge clk);
    cmd_valid = 1'b1;
    ext_mode  = ext;
    cmd_insn  = (noise & ~(32'h7 << 21)) | (32'(hint) << 21);
    if (wr_same) begin
      wr_en = 1'b1; wr_idx = '0; wr_valid = 1'b1;
      wr_esid = 16'hdead; wr_vsid = 24'hbeef; wr_class = 1'b1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_en = 1'b0;
    if (wr_during && busy) begin
      wr_en = 1'b1; wr_idx = IW'(N - 1); wr_valid = 1'b1;
      wr_esid = 16'hface; wr_vsid = 24'hcafe; wr_class = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
    end
    wait (n_done == target);
  endtask

  // Monitor: measures latency, then pops the expected item and compares readback.
  initial begin : monitor
    int lat = 0;
    forever begin
      @(negedge clk);
      if (rst_n && busy) lat++;
      if (rst_n && done) begin
        item_t it;
        logic [N-1:0] v;
        logic ok;
        if (sb_q.size() == 0) begin
          chk("R9 unexpected done", 64'd1, 64'd0);
        end else begin
          it = sb_q.pop_front();
          chk({it.tag, " latency R9"}, 64'(lat), 64'(it.lat));
          chk({it.tag, " flush_req R8"}, 64'(flush_req), 64'd1);
          chk({it.tag, " bad_hint R6"}, 64'(bad_hint), 64'(it.bad));
          @(negedge clk);
          chk({it.tag, " busy low after done R9"}, 64'(busy), 64'd0);
          read_all(v, ok);
          chk({it.tag, " valid mask"}, 64'(v), 64'(it.vld));
          chk({it.tag, " fields kept R7"}, 64'(ok), 64'd1);
        end
        lat = 0;
        n_done++;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_idx = '0; wr_valid = 0; wr_esid = '0; wr_vsid = '0; wr_class = 0;
    rd_idx = '0; cmd_valid = 0; cmd_insn = '0; ext_mode = 0; flush_ack = 0;
    m_vld = '0; m_cls = '0; m_bad = 1'b0;
    fork
      begin : main_seq
        logic [N-1:0] v;
        logic ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 done", 64'(done), 64'd0);
        chk("R11 flush_req", 64'(flush_req), 64'd0);
        chk("R11 bad_hint", 64'(bad_hint), 64'd0);
        for (int i = 0; i < N; i++) begin
          rd_idx = IW'(i); #0.1; v[i] = rd_valid;
        end
        chk("R11 valid mask", 64'(v), 64'd0);

        fill_all();
        run_cmd(3'd3, 1'b0, 32'hffff_ffff, 0, 0, "R2 legacy hint3 noise R1");
        @(negedge clk); flush_ack = 1'b1;
        @(negedge clk); flush_ack = 1'b0;
        chk("R8 flush cleared by ack", 64'(flush_req), 64'd0);
        @(negedge clk);
        chk("R8 flush stays low", 64'(flush_req), 64'd0);

        fill_all();
        run_cmd(3'd0, 1'b1, 32'h0120_0000, 0, 0, "R1 ext hint0 noise");
        fill_all();
        run_cmd(3'd6, 1'b1, 32'h0, 0, 0, "R2 ext hint6");
        fill_all();
        run_cmd(3'd5, 1'b0, 32'h0, 0, 0, "R6 legacy hint5");
        fill_all();
        run_cmd(3'd3, 1'b1, 32'h5a5a_5a5a, 0, 0, "R4 ext hint3");
        fill_all();
        run_cmd(3'd4, 1'b1, 32'h0, 0, 0, "R3 ext hint4");
        fill_all();
        run_cmd(3'd7, 1'b1, 32'hff1f_ffff, 0, 0, "R5 ext hint7");
        run_cmd(3'd5, 1'b1, 32'h0, 0, 0, "R6 ext hint5");
        fill_all();
        run_cmd(3'd1, 1'b1, 32'h0, 0, 0, "R6 sticky then hint1");

        fill_all();
        @(negedge clk); flush_ack = 1'b1;
        @(negedge clk); flush_ack = 1'b0;
        run_cmd(3'd4, 1'b1, 32'h0, 1, 1, "R10 writes stalled");
        // a command and an acknowledge together: the command wins (R8)
        @(negedge clk);
        flush_ack = 1'b1; cmd_valid = 1'b1; ext_mode = 1'b1; cmd_insn = 32'h7 << 21;
        m_vld = m_vld;
        sb_q.push_back('{vld: m_vld, lat: 1, bad: m_bad, tag: "R8 ack vs cmd"});
        begin
          int t;
          t = n_done + 1;
          @(negedge clk);
          flush_ack = 1'b0; cmd_valid = 1'b0;
          wait (n_done == t);
        end
        wr_slot(3, 1'b1, 16'h1234, 24'h5678, 1'b0);
        read_all(v, ok);
        chk("R10 write after idle lands", 64'(v), 64'(m_vld));
        chk("R7 fields after write", 64'(ok), 64'd1);
      end
      begin : watchdog
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 64'd1, 64'd0);
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule